// File: doc/BRIEF.md
# Watchdog Window Control and Closed-Window Enforcement

This block keeps the configuration of a watchdog's window mode and checks every watchdog clear against it. The configuration consists of a window-mode enable and a 4-bit period code. After reset both come from fuse inputs. Software changes them later through an 8-bit register port. Such a write takes effect only when the write sets the change-enable bit and a protection unlock is open. Otherwise the protected fields keep their value.

After each restart, the block counts ticks from a slow 1 kHz low-power oscillator. The period code gives, through a nonlinear table, the number of ticks during which the window stays closed. While the window is closed, a clear of the watchdog is too early and produces a one-cycle reset request. A clear that arrives once the window has opened is accepted and starts a new closed window.

Top module: `wdt_window_ctl`

## Requirements
- R1: After reset, the read value is {2'b00, fuse period, fuse enable, 1'b0}: period in bits 5:2, enable in bit 1, change-enable in bit 0. The reset request is low.
- R2: Bits 7:6 of the read value are always zero, whatever value is written to them.
- R3: A register write with bit 0 cleared leaves the enable and the period unchanged, even while unlocked.
- R4: A write with bit 0 set leaves the enable and the period unchanged when no unlock is open. This covers both no key and a key write more than 4 cycles earlier. The stored change-enable bit (read bit 0) still takes bit 0 of every write.
- R5: A write with bit 0 set in any of the 4 cycles after an unlock-key cycle loads the enable from bit 1 and the period from bits 5:2. The new value is visible on the read value after the next clock edge.
- R6: An accepted protected write closes the unlock, so a second write in the same span is ignored.
- R7: Period codes 0 to 5 give closed windows of 8, 16, 32, 64, 125 and 250 ticks. Codes 6 to 15 give 250 ticks.
- R8: In window mode, a clear that arrives when fewer ticks than the window length have passed since the last restart raises the reset request for one cycle after the clear. The clear also restarts the window.
- R9: In window mode, a clear that arrives after at least the window length in ticks gives no reset request and restarts the closed window.
- R10: With window mode disabled, the closed-window output is low, the period is ignored, and no clear ever raises a reset request.
- R11: The closed-window output is high while window mode is on and fewer ticks than the window length have passed since the last restart.
- R12: An accepted protected write restarts the closed-window count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| fuse_win_en | input | 1 | Reset value of the window-mode enable |
| fuse_period | input | 4 | Reset value of the period code |
| key_wr | input | 1 | Unlock key strobe; opens a 4-cycle write span |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read value |
| tick | input | 1 | One-cycle pulse per low-power oscillator period |
| wd_clear | input | 1 | Watchdog clear request |
| win_closed | output | 1 | High while the closed window is running |
| reset_req | output | 1 | One-cycle early-clear reset request |

## Verification
The bench builds the block with its defaults: an 8-bit tick counter and a 4-cycle unlock span. Because the span is so short, the bench can land a write on both its last open cycle and its first expired cycle. The tick input is driven directly, one pulse per cycle, so even the 250-tick windows can be walked in full. For all sixteen period codes, the bench places a clear one tick before the window opens and another exactly at the opening.

// File: rtl/wwin_pkg.sv
package wwin_pkg;

  localparam int REG_W   = 8;
  localparam int CODE_W  = 4;
  localparam int LEN_W   = 8;

  // bit positions the read/write layout depends on
  localparam int BIT_CEN = 0;
  localparam int BIT_EN  = 1;
  localparam int PER_LO  = 2;
  localparam int PER_HI  = PER_LO + CODE_W - 1;

  typedef struct packed {
    logic              en;
    logic [CODE_W-1:0] per;
  } win_cfg_t;

  // closed-window length in oscillator ticks for a period code
  function automatic logic [LEN_W-1:0] closed_len(input logic [CODE_W-1:0] code);
    logic [LEN_W-1:0] len;
    case (code)
      4'd0:    len = 8'd8;
      4'd1:    len = 8'd16;
      4'd2:    len = 8'd32;
      4'd3:    len = 8'd64;
      4'd4:    len = 8'd125;
      default: len = 8'd250;
    endcase
    return len;
  endfunction

endpackage

// File: rtl/wwin_unlock.sv
module wwin_unlock #(
  parameter int UNLOCK_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic key_wr,
  input  logic consume,
  output logic unlocked
);
  localparam int CW = $clog2(UNLOCK_CYC + 1);

  logic [CW-1:0] span_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      span_q <= '0;
    end else if (key_wr) begin
      span_q <= CW'(UNLOCK_CYC);
    end else if (consume) begin
      span_q <= '0;
    end else if (span_q != '0) begin
      span_q <= span_q - 1'b1;
    end
  end

  assign unlocked = (span_q != '0);
endmodule

// File: rtl/wwin_cfg_reg.sv
module wwin_cfg_reg
  import wwin_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              fuse_win_en,
  input  logic [CODE_W-1:0] fuse_period,
  input  logic              reg_wr,
  input  logic [REG_W-1:0]  reg_wdata,
  input  logic              unlocked,
  output win_cfg_t          cfg,
  output logic              accept,
  output logic [REG_W-1:0]  rdata
);
  win_cfg_t cfg_q;
  logic     cen_q;
  logic     unused_rsvd;

  assign unused_rsvd = ^reg_wdata[REG_W-1:PER_HI+1];

  // protected fields move only with change-enable set and unlock open
  assign accept = reg_wr && reg_wdata[BIT_CEN] && unlocked;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q.en  <= fuse_win_en;
      cfg_q.per <= fuse_period;
      cen_q     <= 1'b0;
    end else begin
      if (reg_wr) begin
        cen_q <= reg_wdata[BIT_CEN];
      end
      if (accept) begin
        cfg_q.en  <= reg_wdata[BIT_EN];
        cfg_q.per <= reg_wdata[PER_HI:PER_LO];
      end
    end
  end

  assign cfg = cfg_q;

  always_comb begin
    rdata                = '0;
    rdata[BIT_CEN]       = cen_q;
    rdata[BIT_EN]        = cfg_q.en;
    rdata[PER_HI:PER_LO] = cfg_q.per;
  end
endmodule

// File: rtl/wwin_window.sv
module wwin_window
  import wwin_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     tick,
  input  logic     wd_clear,
  input  logic     restart,
  input  win_cfg_t cfg,
  output logic     win_closed,
  output logic     reset_req
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;
  logic             req_q;

  assign limit      = CNT_W'(closed_len(cfg.per));
  assign win_closed = cfg.en && (cnt_q < limit);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (wd_clear || restart) begin
      cnt_q <= '0;
    end else if (tick && (cnt_q < limit)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= 1'b0;
    end else begin
      req_q <= wd_clear && win_closed;
    end
  end

  assign reset_req = req_q;
endmodule

// File: rtl/wdt_window_ctl.sv
module wdt_window_ctl
  import wwin_pkg::*;
#(
  parameter int UNLOCK_CYC = 4,
  parameter int CNT_W      = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       fuse_win_en,
  input  logic [3:0] fuse_period,
  input  logic       key_wr,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       tick,
  input  logic       wd_clear,
  output logic       win_closed,
  output logic       reset_req
);
  logic     unlk;
  logic     accept;
  win_cfg_t cfg;

  wwin_unlock #(.UNLOCK_CYC(UNLOCK_CYC)) u_unlock (
    .clk(clk), .rst(rst), .key_wr(key_wr), .consume(accept), .unlocked(unlk)
  );

  wwin_cfg_reg u_cfg (
    .clk(clk), .rst(rst), .fuse_win_en(fuse_win_en), .fuse_period(fuse_period),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .unlocked(unlk),
    .cfg(cfg), .accept(accept), .rdata(reg_rdata)
  );

  wwin_window #(.CNT_W(CNT_W)) u_win (
    .clk(clk), .rst(rst), .tick(tick), .wd_clear(wd_clear), .restart(accept),
    .cfg(cfg), .win_closed(win_closed), .reset_req(reset_req)
  );
endmodule

// File: rtl/wwin_ctl_chk.sv
module wwin_ctl_chk (
  input logic       clk,
  input logic       rst,
  input logic       reg_wr,
  input logic [7:0] reg_wdata,
  input logic [7:0] reg_rdata,
  input logic       wd_clear,
  input logic       win_closed,
  input logic       reset_req,
  input logic       unlk
);
  logic acc;
  assign acc = reg_wr && reg_wdata[0] && unlk;

  // R3, R4: protected fields change only after an accepted write
  a_r4_fields_held: assert property (@(posedge clk) disable iff (rst)
    !$past(acc) |-> $stable(reg_rdata[5:1]));

  // R6: an accepted write closes the unlock span
  a_r6_relock: assert property (@(posedge clk) disable iff (rst)
    acc |=> !unlk);

  // R8: a reset request follows an early clear
  a_r8_req_cause: assert property (@(posedge clk) disable iff (rst)
    reset_req |-> ($past(wd_clear) && $past(win_closed)));

  // R9: a clear with the window open gives no request
  a_r9_open_clear: assert property (@(posedge clk) disable iff (rst)
    (wd_clear && !win_closed) |=> !reset_req);

  // R10, R11: closed window only in window mode
  a_r11_closed_needs_en: assert property (@(posedge clk) disable iff (rst)
    win_closed |-> reg_rdata[1]);

  // R10: no request in normal mode
  a_r10_no_req_normal: assert property (@(posedge clk) disable iff (rst)
    !reg_rdata[1] |=> !reset_req);
endmodule

bind wdt_window_ctl wwin_ctl_chk u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata), .wd_clear(wd_clear), .win_closed(win_closed),
  .reset_req(reset_req), .unlk(unlk)
);

// File: tb/wdt_window_ctl_tb.sv
module wdt_window_ctl_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       fuse_win_en = 1'b1;
  logic [3:0] fuse_period = 4'd2;
  logic       key_wr = 1'b0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       tick = 1'b0;
  logic       wd_clear = 1'b0;
  logic       win_closed;
  logic       reset_req;

  int vectors = 0;
  int miscompares = 0;

  always #2.5 clk = ~clk;

  wdt_window_ctl u_dut (
    .clk(clk), .rst(rst), .fuse_win_en(fuse_win_en), .fuse_period(fuse_period),
    .key_wr(key_wr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tick(tick), .wd_clear(wd_clear), .win_closed(win_closed), .reset_req(reset_req)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int exp_len(input int code);
    case (code)
      0: return 8;
      1: return 16;
      2: return 32;
      3: return 64;
      4: return 125;
      default: return 250;
    endcase
  endfunction

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic key;
    key_wr = 1'b1; @(negedge clk); key_wr = 1'b0;
  endtask

  task automatic wr(input logic [7:0] d);
    reg_wr = 1'b1; reg_wdata = d; @(negedge clk); reg_wr = 1'b0; reg_wdata = 8'h00;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1; @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic clear_expect(input string req, input logic exp_req);
    wd_clear = 1'b1; @(negedge clk); wd_clear = 1'b0;
    check(req, reset_req, exp_req);
    @(negedge clk);
    check({req, " pulse width"}, reset_req, 1'b0);
  endtask

  task automatic cfg(input logic en, input logic [3:0] code);
    key; wr({2'b00, code, en, 1'b1});
  endtask

  task automatic t_reset;
    check("R1 read value", reg_rdata, {2'b00, 4'd2, 1'b1, 1'b0});
    check("R1 request low", reset_req, 1'b0);
    check("R11 closed at start", win_closed, 1'b1);
  endtask

  task automatic t_no_cen;
    key; wr({2'b11, 4'd9, 1'b0, 1'b0});
    check("R3 fields held", reg_rdata[5:1], {4'd2, 1'b1});
    check("R2 reserved zero", reg_rdata[7:6], 2'b00);
  endtask

  task automatic t_locked;
    idle(6);
    wr({2'b00, 4'd7, 1'b0, 1'b1});
    check("R4 locked held", reg_rdata[5:1], {4'd2, 1'b1});
    check("R4 cen writable", reg_rdata[0], 1'b1);
    wr(8'h00);
    check("R4 cen cleared", reg_rdata[0], 1'b0);
    key; idle(4); wr({2'b00, 4'd7, 1'b0, 1'b1});
    check("R4 expired span held", reg_rdata[5:1], {4'd2, 1'b1});
  endtask

  task automatic t_unlock_write;
    key; idle(3); wr({2'b11, 4'd3, 1'b1, 1'b1});
    check("R5 last span cycle accepted", reg_rdata, {2'b00, 4'd3, 1'b1, 1'b1});
    check("R2 reserved after write", reg_rdata[7:6], 2'b00);
    wr({2'b00, 4'd1, 1'b1, 1'b1});
    check("R6 relocked", reg_rdata[5:1], {4'd3, 1'b1});
  endtask

  task automatic t_lengths;
    for (int c = 0; c < 16; c++) begin
      int n = exp_len(c);
      cfg(1'b1, 4'(c));
      ticks(n - 1);
      check($sformatf("R7 closed before len code %0d", c), win_closed, 1'b1);
      clear_expect($sformatf("R8 early clear code %0d", c), 1'b1);
      ticks(n);
      check($sformatf("R7 open at len code %0d", c), win_closed, 1'b0);
      clear_expect($sformatf("R9 late clear code %0d", c), 1'b0);
      check($sformatf("R9 restarted code %0d", c), win_closed, 1'b1);
    end
  endtask

  task automatic t_restart;
    cfg(1'b1, 4'd0);
    ticks(8);
    check("R12 open before rewrite", win_closed, 1'b0);
    cfg(1'b1, 4'd0);
    check("R12 restarted by write", win_closed, 1'b1);
  endtask

  task automatic t_disabled;
    cfg(1'b0, 4'd5);
    check("R10 enable off", reg_rdata[1], 1'b0);
    check("R10 not closed", win_closed, 1'b0);
    clear_expect("R10 no request", 1'b0);
  endtask

  initial begin
    #(5ns * 200000);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    idle(3);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_no_cen;
    t_locked;
    t_unlock_write;
    t_lengths;
    t_restart;
    t_disabled;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule